// File: doc/BRIEF.md
# Third-Order Decimating Filter for a Single-Bit Oversampled Stream

This block turns the one-bit output of a second-order sigma-delta modulator into 16-bit unsigned samples. Every clock edge takes one modulator bit. The bit passes through three running-sum stages at the full bit rate. Once per decimation frame, the sum of the last stage feeds three difference stages. The result is rescaled so that the code is linear in the density of ones. A density of one half reads as mid-scale, and a stream of all ones clips to the top code.

The decimation ratio is fixed when the block is built. A ratio of 256 gives a fine result at the cost of a long frame. A ratio of 32 gives a coarse but fast result, for example to watch for overcurrent next to a high-resolution instance. Each new sample comes with a one-clock strobe. A settle flag stays low until the difference stages have seen three complete frames of input.

Top module: `sinc3_decimator`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs after that edge are `sample_valid`=0, `sample_code`=0 and `settled`=0.
- R2: `sample_valid` is high for exactly one clock in every RATIO clocks. After `rst` is released, the first pulse follows the RATIO-th clock edge.
- R3: The code that comes with a strobe after edge n is min(65535, floor(S·65536/RATIO³)). S is the sum, over k = 0 … 3·RATIO−3, of h[k]·bit[n−3−k]. The weight h is three length-RATIO boxcars convolved together. Bits sampled before reset release count as 0. The code holds between strobes.
- R4: A steady stream of ones gives code 65535 (0xFFFF) for both ratio 256 and ratio 32.
- R5: A steady 50 % density (alternating bits) gives 32768, and a steady stream of zeros gives 0.
- R6: A steady density of 13/16 ones gives 53248, and 3/16 ones gives 12288.
- R7: `settled` is low on the first three strobes after reset and high from the fourth strobe onward. Once high, it stays high until reset.
- R8: The running sums wrap in two's complement with 3·log2(RATIO)+1 bits. The value entering the scaler never exceeds RATIO³, even after the sums have wrapped many times.
- R9: A reset in the middle of a frame clears all filter state and the frame counter. Later outputs behave as from a fresh start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Modulator bit clock; one bit per rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sd_bit | input | 1 | Single-bit modulator data |
| sample_code | output | 16 | Decimated unsigned result |
| sample_valid | output | 1 | One-clock strobe per new result |
| settled | output | 1 | High once three full frames have passed through the filter |

## Verification
A corrupted running sum or difference register shows up at the next strobe as a code far from the density-derived value. Because the difference stages keep state, that error persists across up to three strobes. That is at most 3·RATIO clocks: 768 for the slow variant and 96 for the fast one. A frame counter that is off by one moves the strobe, which a per-cycle timing check catches within one frame. A wrong scaling shift moves the steady-state codes for the all-ones, half-density and 13/16 patterns away from their fixed targets.

// File: rtl/sinc3_pkg.sv
package sinc3_pkg;

  localparam int ORDER  = 3;
  localparam int CODE_W = 16;

  // Accumulator width needed so the final difference is exact.
  function automatic int acc_width(input int lg);
    return ORDER * lg + 1;
  endfunction

  // Map the raw difference (0 .. 2^(ORDER*lg)) onto a 16-bit code.
  function automatic logic [CODE_W-1:0] raw_to_code(input logic [63:0] raw, input int lg);
    int          sh;
    logic [63:0] v;
    sh = ORDER * lg - CODE_W;
    if (sh >= 0) v = raw >> sh;
    else         v = raw << (-sh);
    if (v > 64'd65535) return 16'hFFFF;
    return v[CODE_W-1:0];
  endfunction

endpackage

// File: rtl/sinc3_phase.sv
module sinc3_phase #(
  parameter int RATIO = 256,
  localparam int LG = $clog2(RATIO)
) (
  input  logic          clk,
  input  logic          rst,
  output logic          frame_tick,
  output logic [LG-1:0] phase
);
  localparam logic [LG-1:0] LAST = LG'(RATIO - 1);

  logic [LG-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign frame_tick = (cnt_q == LAST);
  assign phase      = cnt_q;
endmodule

// File: rtl/sinc3_integ.sv
module sinc3_integ #(
  parameter int W = 25
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] addend,
  output logic [W-1:0] acc
);
  // Wrap-around running sum; the difference stages undo the wrap.
  always_ff @(posedge clk) begin
    if (rst) acc <= '0;
    else     acc <= acc + addend;
  end
endmodule

// File: rtl/sinc3_diff.sv
module sinc3_diff #(
  parameter int W = 25
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         frame_tick,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] held_q;

  always_ff @(posedge clk) begin
    if (rst)             held_q <= '0;
    else if (frame_tick) held_q <= din;
  end

  assign dout = din - held_q;
endmodule

// File: rtl/sinc3_decimator.sv
module sinc3_decimator
  import sinc3_pkg::*;
#(
  parameter int RATIO = 256
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        sd_bit,
  output logic [15:0] sample_code,
  output logic        sample_valid,
  output logic        settled
);
  localparam int LG = $clog2(RATIO);
  localparam int W  = acc_width(LG);
  localparam logic [W-1:0] FULL_RAW = {1'b1, {(W-1){1'b0}}};

  logic [ORDER:0][W-1:0] integ_bus;
  logic [ORDER:0][W-1:0] diff_bus;
  logic                  frame_tick;
  logic [LG-1:0]         phase;
  logic [W-1:0]          raw;

  logic [15:0] code_q;
  logic        valid_q;
  logic        settled_q;
  logic [1:0]  seen_q;

  sinc3_phase #(.RATIO(RATIO)) u_phase (
    .clk(clk), .rst(rst), .frame_tick(frame_tick), .phase(phase)
  );

  assign integ_bus[0] = {{(W-1){1'b0}}, sd_bit};

  for (genvar s = 0; s < ORDER; s++) begin : g_integ
    sinc3_integ #(.W(W)) u_integ (
      .clk(clk), .rst(rst), .addend(integ_bus[s]), .acc(integ_bus[s+1])
    );
  end

  assign diff_bus[0] = integ_bus[ORDER];

  for (genvar s = 0; s < ORDER; s++) begin : g_diff
    sinc3_diff #(.W(W)) u_diff (
      .clk(clk), .rst(rst), .frame_tick(frame_tick),
      .din(diff_bus[s]), .dout(diff_bus[s+1])
    );
  end

  assign raw = diff_bus[ORDER];

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q    <= '0;
      valid_q   <= 1'b0;
      settled_q <= 1'b0;
      seen_q    <= '0;
    end else begin
      valid_q <= frame_tick;
      if (frame_tick) begin
        code_q    <= raw_to_code(64'(raw), LG);
        settled_q <= (seen_q == 2'd3);
        if (seen_q != 2'd3) seen_q <= seen_q + 2'd1;
      end
    end
  end

  assign sample_code  = code_q;
  assign sample_valid = valid_q;
  assign settled      = settled_q;

  AST_RAW_BOUND: assert property (@(posedge clk) disable iff (rst)
    frame_tick |-> (raw <= FULL_RAW)); // R8
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    valid_q |=> !valid_q); // R2
  AST_VALID_PHASE: assert property (@(posedge clk) disable iff (rst)
    valid_q |-> (phase == '0)); // R2
  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !valid_q |-> $stable(code_q)); // R3
  AST_SETTLED_STICKY: assert property (@(posedge clk) disable iff (rst)
    settled_q |=> settled_q); // R7
endmodule

// File: tb/sinc3_decimator_test.sv
`timescale 1ns/1ps
module sinc3_decimator_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sd_bit = 1'b0;
  logic [15:0] code_s, code_f;
  logic val_s, val_f, set_s, set_f;

  always #2.5 clk = ~clk;

  sinc3_decimator uut (
    .clk(clk), .rst(rst), .sd_bit(sd_bit),
    .sample_code(code_s), .sample_valid(val_s), .settled(set_s)
  );
  sinc3_decimator #(.RATIO(32)) uut_fast (
    .clk(clk), .rst(rst), .sd_bit(sd_bit),
    .sample_code(code_f), .sample_valid(val_f), .settled(set_f)
  );

  int tests = 0, fails = 0;
  int n = 0;
  bit hist [0:65535];
  longint hk [2][0:767];
  int seen [2];
  int last_code [2];
  bit done = 0;

  function automatic longint gtri(input int r, input int m);
    if (m < 0 || m > 2*r-2) return 0;
    return (m + 1 < 2*r - 1 - m) ? m + 1 : 2*r - 1 - m;
  endfunction

  task automatic build(input int sel, input int r);
    for (int k = 0; k < 3*r-2; k++) begin
      longint acc = 0;
      for (int c = 0; c < r; c++) acc += gtri(r, k - c);
      hk[sel][k] = acc;
    end
  endtask

  function automatic int expect_code(input int sel, input int r, input int e);
    longint s = 0;
    longint c;
    for (int k = 0; k <= 3*r-3; k++) begin
      int idx = e - 3 - k;
      if (idx >= 0 && hist[idx]) s += hk[sel][k];
    end
    c = (s * 65536) / (longint'(r) * r * r);
    if (c > 65535) c = 65535;
    return int'(c);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (n=%0d)", req, act, exp, n);
    end
  endtask

  task automatic chk_one(input int sel, input int r, input logic v, input logic [15:0] c, input logic st);
    bit ev = ((n + 1) % r) == 0;
    check("R2 strobe timing", int'(v), int'(ev));
    if (v && ev) begin
      seen[sel]++;
      check("R3 code", int'(c), expect_code(sel, r, n));
      check("R7 settled", int'(st), (seen[sel] >= 4) ? 1 : 0);
      last_code[sel] = int'(c);
    end
  endtask

  task automatic step(input bit b);
    sd_bit = b;
    hist[n] = b;
    @(posedge clk);
    @(negedge clk);
    chk_one(0, 256, val_s, code_s, set_s);
    chk_one(1, 32, val_f, code_f, set_f);
    n++;
  endtask

  task automatic do_reset(input string req);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check({req, " valid"}, int'(val_s) + int'(val_f), 0);
    check({req, " code"}, int'(code_s) + int'(code_f), 0);
    check({req, " settled"}, int'(set_s) + int'(set_f), 0);
    rst = 1'b0;
    n = 0;
    seen[0] = 0;
    seen[1] = 0;
  endtask

  task automatic run_pattern(input int ones_of_16, input int cycles);
    for (int i = 0; i < cycles; i++) step((i % 16) < ones_of_16);
  endtask

  initial begin
    fork
      begin
        #(5.0 * 200000);
        if (!done) begin
          fails++;
          $display("FAIL watchdog expired");
          $display("[TB] %0d tests run, %0d failed", tests, fails);
          $finish;
        end
      end
    join_none
  end

  initial begin
    build(0, 256);
    build(1, 32);
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk);
    do_reset("R1");

    run_pattern(0, 1280);
    check("R5 zeros slow", last_code[0], 0);
    check("R5 zeros fast", last_code[1], 0);

    run_pattern(16, 1280);
    check("R4 ones slow", last_code[0], 65535);
    check("R4 ones fast", last_code[1], 65535);

    // long all-ones run wraps the running sums many times (R8)
    run_pattern(16, 6000);
    check("R8 wrapped slow", last_code[0], 65535);
    check("R8 wrapped fast", last_code[1], 65535);

    for (int i = 0; i < 1280; i++) step(i[0]);
    check("R5 half slow", last_code[0], 32768);
    check("R5 half fast", last_code[1], 32768);

    run_pattern(13, 1280);
    check("R6 13/16 slow", last_code[0], 53248);
    check("R6 13/16 fast", last_code[1], 53248);

    run_pattern(3, 1280);
    check("R6 3/16 slow", last_code[0], 12288);
    check("R6 3/16 fast", last_code[1], 12288);

    for (int seg = 0; seg < 6; seg++) begin
      int p = $urandom % 101;
      for (int i = 0; i < 600; i++) step(($urandom % 100) < p);
    end

    // reset partway through a frame (R9)
    for (int i = 0; i < 100; i++) step($urandom % 2);
    do_reset("R9");
    run_pattern(13, 1280);
    check("R9 after reset slow", last_code[0], 53248);
    check("R9 after reset fast", last_code[1], 53248);
    for (int i = 0; i < 900; i++) step(($urandom % 100) < 70);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule